// File: doc/BRIEF.md
# Page-Mode Flash Read Sequencer

This block sits on the host side of a parallel NOR-style flash and turns short burst read requests into asynchronous page-mode read cycles. A request carries a 22-bit word address and a length of one to four words. The sequencer drives a shared select / output-enable pair and the word address. It then counts clock cycles until the device data can be trusted, samples the 16-bit data bus, and hands each word to a response stream. The last word of a burst is flagged.

The device groups words into four-word pages that share every address bit above the lowest two. The first word read from a page must wait the full access latency (`INIT_LAT` clocks, default 9). Any later word in the same page, in any order of the two low bits, waits only the page latency (`PAGE_LAT` clocks, default 3), as long as the device has stayed selected. A burst runs through consecutive addresses. When it steps from low bits `11` to `00`, it enters a new page and pays the full latency again.

Request port: a request moves when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` stays low while a word access is in progress. Response port: a word moves when `rsp_valid` and `rsp_ready` are both high. While the consumer holds `rsp_ready` low, the held word does not change and the sequencer stalls on its current address instead of sampling again. No word is dropped.

Top module: `page_read_seq`

## Requirements
- R1: During and straight after reset, `flash_ce_n` and `flash_oe_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_len` holds the word count minus one (0 gives 1 word, 3 gives 4 words). `req_ready` is low for as long as a word access is in progress.
- R3: When the device was deselected before the request, the word address is driven for exactly `INIT_LAT` clock cycles, and the data is sampled at the end of the last of them.
- R4: Within a burst, a word whose address bits 21..2 equal those of the previous word is driven for `PAGE_LAT` cycles before sampling.
- R5: A burst reads addresses start, start+1, and so on, modulo 2^22. A step that changes bits 21..2 (low bits going from 3 to 0) costs the full `INIT_LAT`.
- R6: A request taken in the cycle directly after a burst's final sample keeps the device selected. If its bits 21..2 match the previous word it waits `PAGE_LAT`, whatever its low two bits are; otherwise it waits `INIT_LAT`.
- R7: If no request is valid in the cycle after a burst's final sample, `flash_ce_n` and `flash_oe_n` go high on the next edge. The two are always low or high together.
- R8: `rsp_data` equals the value on `flash_dq` at the sampling edge. `rsp_last` is 1 only on a burst's final word.
- R9: While `rsp_valid` is high and `rsp_ready` low, `rsp_data` and `rsp_last` hold and no new sample is taken. The sequencer keeps driving the waiting word's address until the slot frees.
- R10: `flash_addr` does not change during a word's wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 22 | First word address of the burst |
| req_len | input | 2 | Burst length in words minus one |
| rsp_valid | output | 1 | Response word held |
| rsp_ready | input | 1 | Consumer takes the held word |
| rsp_data | output | 16 | Response word |
| rsp_last | output | 1 | Final word of the burst |
| flash_ce_n | output | 1 | Device select, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_addr | output | 22 | Word address to the device |
| flash_dq | input | 16 | Data bus from the device |

## Verification
The main function is driven in several ways:
- Single words from a deselected device separate the full latency from the page latency.
- Aligned four-word bursts show the page latency on the second to fourth words.
- Unaligned bursts and a burst at the top of the address space show whether page crossings, including the wrap back to zero, are charged the full latency.
- Back-to-back single-word requests that visit one page in the order 3, 0, 2, 1 and are then followed by a foreign page show whether page hits are judged on the upper address bits alone.

A responder in the bench returns junk data until the address has been held long enough, so sampling too early shows up in the data. Runs with a randomly stalling consumer separate correct holding from dropped or repeated words.

// File: rtl/pr_pkg.sv
package pr_pkg;
  // log2 of words per page; also the width of the burst length field
  localparam int PAGE_LG = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // device deselected
    ST_WAIT = 2'd1,  // counting down one word access
    ST_HOLD = 2'd2   // burst done, device still selected for one cycle
  } pr_state_e;
endpackage

// File: rtl/pr_wait_timer.sv
module pr_wait_timer #(
  parameter int CW   = 4,
  parameter int MAXV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  // Counts down to zero and parks there until reloaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R3: no wait count exceeds the full access latency
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAXV);
endmodule

// File: rtl/pr_page_seq.sv
module pr_page_seq
  import pr_pkg::*;
#(
  parameter int AW       = 22,
  parameter int CW       = 4,
  parameter int INIT_LAT = 9,
  parameter int PAGE_LAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [PAGE_LG-1:0] req_len_i,
  input  logic               slot_free_i,
  input  logic               tmr_expired_i,
  output logic               tmr_load_o,
  output logic [CW-1:0]      tmr_val_o,
  output logic               capture_o,
  output logic               last_o,
  output logic               ce_n_o,
  output logic               oe_n_o,
  output logic [AW-1:0]      addr_o
);
  localparam logic [CW-1:0] FULL_M1 = CW'(INIT_LAT - 1);
  localparam logic [CW-1:0] PAGE_M1 = CW'(PAGE_LAT - 1);

  pr_state_e          state_q;
  logic [AW-1:0]      cur_q;
  logic [PAGE_LG-1:0] left_q;

  logic          accept;
  logic          same_page;
  logic          crosses;
  logic [AW-1:0] step_addr;

  assign req_ready_o = (state_q != ST_WAIT);
  assign accept      = req_valid_i && req_ready_o;
  assign capture_o   = (state_q == ST_WAIT) && tmr_expired_i && slot_free_i;
  assign last_o      = (left_q == '0);

  assign step_addr = cur_q + AW'(1);
  assign crosses   = (step_addr[AW-1:PAGE_LG] != cur_q[AW-1:PAGE_LG]);
  // A page hit is only possible while the device stayed selected
  assign same_page = (state_q == ST_HOLD) &&
                     (req_addr_i[AW-1:PAGE_LG] == cur_q[AW-1:PAGE_LG]);

  assign tmr_load_o = accept || (capture_o && !last_o);
  always_comb begin
    if (accept) tmr_val_o = same_page ? PAGE_M1 : FULL_M1;
    else        tmr_val_o = crosses   ? FULL_M1 : PAGE_M1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            state_q <= ST_WAIT;
            cur_q   <= req_addr_i;
            left_q  <= req_len_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (capture_o) begin
            if (last_o) begin
              state_q <= ST_HOLD;
            end else begin
              cur_q  <= step_addr;
              left_q <= left_q - PAGE_LG'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_n_o = (state_q == ST_IDLE);
  assign oe_n_o = (state_q == ST_IDLE);
  assign addr_o = cur_q;

  // R10: the address holds while a word is still being waited on
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !capture_o) |=> $stable(addr_o));

  // R7: an idle cycle after a burst deselects the device
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !req_valid_i) |=> (ce_n_o && oe_n_o));

  // R2: a burst is only started from a non-busy state
  p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_WAIT) |-> $past(req_valid_i));
endmodule

// File: rtl/pr_rsp_slot.sv
module pr_rsp_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  output logic          free_o,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_data_o,
  output logic          rsp_last_o
);
  assign free_o = !rsp_valid_o || rsp_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_last_o  <= 1'b0;
    end else if (capture_i) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= data_i;
      rsp_last_o  <= last_i;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R9: a stalled word is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o)));

  // R9: no sample may overwrite a word the consumer has not taken
  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !capture_i);
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int INIT_LAT = 9,
  parameter int PAGE_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_dq
);
  localparam int CW = $clog2(INIT_LAT + 1);

  logic          slot_free;
  logic          tmr_expired;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          capture;
  logic          last_word;

  pr_page_seq #(
    .AW(ADDR_W), .CW(CW), .INIT_LAT(INIT_LAT), .PAGE_LAT(PAGE_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .slot_free_i(slot_free), .tmr_expired_i(tmr_expired),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .capture_o(capture), .last_o(last_word),
    .ce_n_o(flash_ce_n), .oe_n_o(flash_oe_n), .addr_o(flash_addr)
  );

  pr_wait_timer #(.CW(CW), .MAXV(INIT_LAT - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(tmr_expired)
  );

  pr_rsp_slot #(.DW(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .capture_i(capture), .data_i(flash_dq), .last_i(last_word),
    .free_o(slot_free),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .rsp_last_o(rsp_last)
  );

  // R8: data is only sampled while the device drives the bus
  p_cap_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!flash_ce_n && !flash_oe_n));

  // R2: a deselected sequencer always accepts
  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ce_n |-> req_ready);
endmodule

// File: tb/sim_page_read_seq.sv
module sim_page_read_seq;
  localparam int INIT = 9;
  localparam int PAGE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        rsp_last;
  logic        flash_ce_n, flash_oe_n;
  logic [21:0] flash_addr;
  logic [15:0] flash_dq;

  int vecs = 0;
  int fails = 0;
  bit done = 0;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  page_read_seq #(.INIT_LAT(INIT), .PAGE_LAT(PAGE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_addr(flash_addr), .flash_dq(flash_dq)
  );

  function automatic logic [15:0] memf(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], a[21:16], 4'h9};
  endfunction

  // Device responder: junk until the address has been held long enough
  int  word_age = 0, page_age = 0;
  logic [21:0] prev_addr = '0;
  bit  prev_sel = 0;
  int  word_cur, page_cur;
  always_comb begin
    word_cur = (!flash_ce_n && prev_sel && flash_addr == prev_addr) ? word_age + 1 : 1;
    page_cur = (!flash_ce_n && prev_sel && flash_addr[21:2] == prev_addr[21:2]) ? page_age + 1 : 1;
    if (flash_ce_n || flash_oe_n)                 flash_dq = 16'hFFFF;
    else if (page_cur >= INIT && word_cur >= PAGE) flash_dq = memf(flash_addr);
    else                                           flash_dq = flash_addr[15:0] ^ 16'h5A5A;
  end
  always @(posedge clk) begin
    word_age  <= word_cur;
    page_age  <= page_cur;
    prev_addr <= flash_addr;
    prev_sel  <= !flash_ce_n;
  end

  // Behavioural reference: 0 idle, 1 waiting on a word, 2 selected after burst
  int m_st = 0, m_cnt = 0, m_rem = 0;
  logic [21:0] m_addr = '0;
  bit m_rv = 0, m_rl = 0;
  logic [15:0] m_rd = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rem = 0; m_addr = '0; m_rv = 0; m_rl = 0; m_rd = '0;
    end else begin
      bit cap;
      logic [21:0] na;
      cap = (m_st == 1 && m_cnt == 0 && (!m_rv || rsp_ready));
      if (cap) begin
        m_rv = 1; m_rd = memf(m_addr); m_rl = (m_rem == 0);
      end else if (rsp_ready) m_rv = 0;
      case (m_st)
        0: if (req_valid) begin
             m_addr = req_addr; m_rem = int'(req_len); m_cnt = INIT - 1; m_st = 1;
           end
        1: if (m_cnt > 0) m_cnt = m_cnt - 1;
           else if (cap) begin
             if (m_rem == 0) m_st = 2;
             else begin
               na = m_addr + 22'd1;
               m_cnt = (na[21:2] != m_addr[21:2]) ? INIT - 1 : PAGE - 1;
               m_addr = na; m_rem = m_rem - 1;
             end
           end
        default: if (req_valid) begin
             m_cnt = (req_addr[21:2] == m_addr[21:2]) ? PAGE - 1 : INIT - 1;
             m_addr = req_addr; m_rem = int'(req_len); m_st = 1;
           end else m_st = 0;
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      vecs++;
      if (flash_ce_n !== (m_st == 0) || flash_oe_n !== flash_ce_n) begin
        $display("FAIL R3 R6 R7 select: ce=%b oe=%b expected %b", flash_ce_n, flash_oe_n, m_st == 0); bad = 1;
      end
      if (req_ready !== (m_st != 1)) begin
        $display("FAIL R2 req_ready: %b expected %b", req_ready, m_st != 1); bad = 1;
      end
      if (m_st != 0 && flash_addr !== m_addr) begin
        $display("FAIL R5 R10 flash_addr: %h expected %h", flash_addr, m_addr); bad = 1;
      end
      if (rsp_valid !== m_rv) begin
        $display("FAIL R3 R4 R9 rsp_valid: %b expected %b", rsp_valid, m_rv); bad = 1;
      end else if (m_rv && (rsp_data !== m_rd || rsp_last !== m_rl)) begin
        $display("FAIL R8 rsp: data=%h last=%b expected %h %b", rsp_data, rsp_last, m_rd, m_rl); bad = 1;
      end
      if (bad) fails++;
    end
  end

  // Consumer readiness: always ready, or pseudo-random stalls
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic send(input logic [21:0] a, input logic [1:0] n);
    bit ok;
    req_valid = 1'b1; req_addr = a; req_len = n;
    do begin ok = req_ready; @(negedge clk); end while (!ok);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    @(negedge clk);
    while (m_st != 0 || m_rv || rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    vecs++;
    if (flash_ce_n !== 1 || flash_oe_n !== 1 || rsp_valid !== 0 || req_ready !== 1) begin
      fails++;
      $display("FAIL R1 reset: ce=%b oe=%b rv=%b rdy=%b expected 1 1 0 1",
               flash_ce_n, flash_oe_n, rsp_valid, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single word from deselected device, measured directly
    send(22'h001234, 2'd0);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    vecs++;
    if (n != INIT) begin
      fails++;
      $display("FAIL R3 initial latency: %0d expected %0d", n, INIT);
    end
    drain();

    // R4: aligned four-word burst
    send(22'h00A0C0, 2'd3); drain();
    // R5: unaligned bursts crossing a page, and top-of-space wrap
    send(22'h00A0C2, 2'd3); drain();
    send(22'h3FFFFE, 2'd3); drain();
    send(22'h000107, 2'd1); drain();

    // R6: back-to-back page hits in order 3,0,2,1, then a foreign page
    send(22'h012343, 2'd0);
    send(22'h012340, 2'd0);
    send(22'h012342, 2'd0);
    send(22'h012341, 2'd1);
    send(22'h0ABCD0, 2'd0);
    drain();

    // R7: gap of idle cycles then same page again must pay full latency
    send(22'h012343, 2'd0); req_valid = 1'b0;
    repeat (20) @(negedge clk);
    send(22'h012342, 2'd0); drain();

    // R9: stalling consumer with mixed bursts
    stall_mode = 1;
    for (int i = 0; i < 40; i++) begin
      send(22'(i * 22'h01F3 + 22'h2001), 2'(i % 4));
      if (i % 3 == 0) begin req_valid = 1'b0; @(negedge clk); end
    end
    drain();
    stall_mode = 0;
    for (int i = 0; i < 12; i++) send(22'h300000 + 22'(i * 3), 2'(i % 4));
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule